// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is a single output cell for a programmable logic array. It takes the sum-of-products result for one output, the shared preset and clear terms, the cell's own output-enable term and the clock. Inside it are one rising-edge D flip-flop and two selectors. Two configuration bits pick the output type and the output polarity. One bit chooses the flip-flop or the raw sum. The other chooses active-high or active-low.

The cell drives a pin model. The pin model has three separate signals: a drive value, a drive enable and the level read back from the pad. The cell also returns a feedback bit to the array. In registered modes the feedback is the flip-flop state. In combinational modes it is the pad level. So, through the enable term, the pin can serve as a dedicated output, a dedicated input or a bidirectional line.

Top module: `oc_top`

## Requirements
- R1: When neither preset nor clear is true, a rising clock edge loads the flip-flop with `sumTerm`.
- R2: A true `presetTerm` with `clearTerm` false sets the flip-flop to 1 at the next rising clock edge. It has no effect before that edge.
- R3: A true `clearTerm` drives the flip-flop to 0 at once, without waiting for a clock edge, and holds it at 0 while it stays true.
- R4: When `presetTerm` and `clearTerm` are true together, the flip-flop is 0.
- R5: When `cfgCombSel` is 0 the output path takes the flip-flop state. When it is 1 the output path takes `sumTerm` directly, and the pin follows it with no clock edge.
- R6: When `cfgActiveHigh` is 1 the pin value equals the selected signal. When it is 0 the pin value is its inverse. Polarity is applied after the registered/combinational choice, so registered active-low drives the inverse of the flip-flop.
- R7: `feedback` equals the flip-flop state when `cfgCombSel` is 0, and equals `padIn` when `cfgCombSel` is 1.
- R8: `padOe` is 1 exactly when `enableTerm` is 1 (0 means high impedance). With the enable false in combinational mode, the cell acts as a dedicated input and `feedback` follows the external pad level.
- R9: While `rstN` is 0 (power-on), the flip-flop is held at 0, and it is still 0 when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, rising edge |
| rstN | input | 1 | Active-low power-on clear |
| sumTerm | input | 1 | Sum-of-products result for this output |
| presetTerm | input | 1 | Shared synchronous preset term |
| clearTerm | input | 1 | Shared asynchronous clear term |
| enableTerm | input | 1 | Output-enable product term for this pin |
| cfgCombSel | input | 1 | Output type: 0 registered, 1 combinational |
| cfgActiveHigh | input | 1 | Polarity: 0 active low, 1 active high |
| padIn | input | 1 | Level present on the pad |
| padDrive | output | 1 | Value driven onto the pad |
| padOe | output | 1 | Pad driver enable, 0 means high impedance |
| feedback | output | 1 | Signal returned to the array |

## Verification
On every clock edge the assertions check the flip-flop against the preset, clear and load rules. They check the clear priority, the feedback source for each mode, the registered-path polarity and the state just after power-on. The combinational path and the asynchronous clear act between edges, so only the bench can show them. It sweeps all four configurations against every combination of sum, preset, clear, enable and external pad level. It checks the outputs both mid-cycle and just after each edge, and it models a pad that reads back the cell's own drive whenever the enable is on.

// File: rtl/oc_pkg.sv
package oc_pkg;
  // Strobes handed from the control decode to the datapath.
  typedef struct packed {
    logic clrAsync;    // asynchronous clear of the flip-flop
    logic loadPreset;  // synchronous set at the next edge
    logic selComb;     // output path takes the raw sum
    logic invert;      // active-low polarity
    logic drive;       // pad driver on
    logic fbFromPin;   // feedback from the pad instead of the flip-flop
  } ocStrobe_t;

  localparam logic RESET_STATE = 1'b0;
endpackage

// File: rtl/oc_ctrl.sv
module oc_ctrl
  import oc_pkg::*;
(
  input  logic      rstN,
  input  logic      presetTerm,
  input  logic      clearTerm,
  input  logic      enableTerm,
  input  logic      cfgCombSel,
  input  logic      cfgActiveHigh,
  output ocStrobe_t strobe
);
  always_comb begin
    // Power-on and the clear term share the asynchronous path.
    strobe.clrAsync   = clearTerm | ~rstN;
    // Clear outranks preset.
    strobe.loadPreset = presetTerm & ~clearTerm;
    strobe.selComb    = cfgCombSel;
    strobe.invert     = ~cfgActiveHigh;
    strobe.drive      = enableTerm;
    strobe.fbFromPin  = cfgCombSel;
  end
endmodule

// File: rtl/oc_datapath.sv
module oc_datapath
  import oc_pkg::*;
(
  input  logic      clk,
  input  ocStrobe_t strobe,
  input  logic      sumTerm,
  input  logic      padIn,
  output logic      padDrive,
  output logic      padOe,
  output logic      feedback,
  output logic      qState
);
  logic clrAsync;
  logic selected;

  assign clrAsync = strobe.clrAsync;

  always_ff @(posedge clk or posedge clrAsync) begin
    if (clrAsync)               qState <= RESET_STATE;
    else if (strobe.loadPreset) qState <= 1'b1;
    else                        qState <= sumTerm;
  end

  always_comb begin
    selected = strobe.selComb ? sumTerm : qState;
    padDrive = strobe.invert ? ~selected : selected;
    padOe    = strobe.drive;
    feedback = strobe.fbFromPin ? padIn : qState;
  end
endmodule

// File: rtl/oc_top.sv
module oc_top
  import oc_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic sumTerm,
  input  logic presetTerm,
  input  logic clearTerm,
  input  logic enableTerm,
  input  logic cfgCombSel,
  input  logic cfgActiveHigh,
  input  logic padIn,
  output logic padDrive,
  output logic padOe,
  output logic feedback
);
  ocStrobe_t strobe;
  logic      qState;

  oc_ctrl u_ctrl (
    .rstN          (rstN),
    .presetTerm    (presetTerm),
    .clearTerm     (clearTerm),
    .enableTerm    (enableTerm),
    .cfgCombSel    (cfgCombSel),
    .cfgActiveHigh (cfgActiveHigh),
    .strobe        (strobe)
  );

  oc_datapath u_dp (
    .clk      (clk),
    .strobe   (strobe),
    .sumTerm  (sumTerm),
    .padIn    (padIn),
    .padDrive (padDrive),
    .padOe    (padOe),
    .feedback (feedback),
    .qState   (qState)
  );
endmodule

// File: rtl/oc_checker.sv
module oc_checker (
  input logic clk,
  input logic rstN,
  input logic sumTerm,
  input logic presetTerm,
  input logic clearTerm,
  input logic cfgCombSel,
  input logic cfgActiveHigh,
  input logic padIn,
  input logic padDrive,
  input logic feedback,
  input logic qState
);
  AST_LOAD_SUM: assert property (@(posedge clk) disable iff (!rstN)
    (!presetTerm && !clearTerm) |=> (clearTerm || qState == $past(sumTerm))); // R1

  AST_PRESET_SET: assert property (@(posedge clk) disable iff (!rstN)
    (presetTerm && !clearTerm) |=> (clearTerm || qState)); // R2

  AST_CLEAR_LOW: assert property (@(posedge clk) disable iff (!rstN)
    clearTerm |-> !qState); // R3

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (clearTerm && presetTerm) |-> !qState); // R4

  AST_REG_POLARITY: assert property (@(posedge clk) disable iff (!rstN)
    !cfgCombSel |-> (padDrive == (cfgActiveHigh ? qState : !qState))); // R6

  AST_FB_REGISTER: assert property (@(posedge clk) disable iff (!rstN)
    !cfgCombSel |-> (feedback == qState)); // R7

  AST_FB_PIN: assert property (@(posedge clk) disable iff (!rstN)
    cfgCombSel |-> (feedback == padIn)); // R7

  AST_POWERON_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !qState); // R9
endmodule

bind oc_top oc_checker u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .sumTerm       (sumTerm),
  .presetTerm    (presetTerm),
  .clearTerm     (clearTerm),
  .cfgCombSel    (cfgCombSel),
  .cfgActiveHigh (cfgActiveHigh),
  .padIn         (padIn),
  .padDrive      (padDrive),
  .feedback      (feedback),
  .qState        (qState)
);

// File: tb/tb_oc_top.sv
`timescale 1ns/1ps
module tb_oc_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sumTerm = 1'b0, presetTerm = 1'b0, clearTerm = 1'b0, enableTerm = 1'b0;
  logic cfgCombSel = 1'b0, cfgActiveHigh = 1'b1;
  logic extLevel = 1'b0;
  logic padIn, padDrive, padOe, feedback;

  int   testsRun = 0;
  int   testsFailed = 0;
  logic refQ = 1'b0;
  bit   finished = 1'b0;

  always #2.5 clk = ~clk;

  // Pad model: the cell's own drive wins while enabled.
  assign padIn = padOe ? padDrive : extLevel;

  oc_top dut (
    .clk(clk), .rstN(rstN), .sumTerm(sumTerm), .presetTerm(presetTerm),
    .clearTerm(clearTerm), .enableTerm(enableTerm), .cfgCombSel(cfgCombSel),
    .cfgActiveHigh(cfgActiveHigh), .padIn(padIn), .padDrive(padDrive),
    .padOe(padOe), .feedback(feedback)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  function automatic logic expPad(input logic q);
    logic sel;
    sel = cfgCombSel ? sumTerm : q;
    return cfgActiveHigh ? sel : ~sel;
  endfunction

  function automatic logic expFb(input logic q);
    logic pin;
    pin = enableTerm ? expPad(q) : extLevel;
    return cfgCombSel ? pin : q;
  endfunction

  task automatic checkAll(input string regTag);
    check("R8", "padOe", padOe, enableTerm);
    check(cfgCombSel ? "R5" : "R6", "padDrive", padDrive, expPad(refQ));
    check(cfgCombSel ? "R7" : regTag, "feedback", feedback, expFb(refQ));
  endtask

  task automatic applyVector(input logic [1:0] cfg, input logic [4:0] v);
    string tag;
    @(negedge clk);
    cfgCombSel    = cfg[1];
    cfgActiveHigh = cfg[0];
    sumTerm       = v[0];
    presetTerm    = v[1];
    clearTerm     = v[2];
    enableTerm    = v[3];
    extLevel      = v[4];
    if (clearTerm) refQ = 1'b0;        // asynchronous clear
    #1;
    // Mid-cycle: the combinational path and the clear act now; preset waits.
    tag = clearTerm ? (presetTerm ? "R4" : "R3") : (presetTerm ? "R2" : "R5");
    checkAll(tag);
    @(posedge clk);
    if (clearTerm)       refQ = 1'b0;
    else if (presetTerm) refQ = 1'b1;
    else                 refQ = sumTerm;
    #1;
    tag = clearTerm ? (presetTerm ? "R4" : "R3") : (presetTerm ? "R2" : "R1");
    checkAll(tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin : main
    // Power-on: try to set the flip-flop while reset is held.
    sumTerm = 1'b1;
    presetTerm = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R9", "feedback in reset", feedback, 1'b0);
    check("R9", "padDrive in reset", padDrive, 1'b0);
    @(negedge clk);
    presetTerm = 1'b0;
    sumTerm = 1'b0;
    rstN = 1'b1;
    #1;
    check("R9", "feedback after release", feedback, 1'b0);
    refQ = 1'b0;

    // Sweep every configuration against every input pattern, twice, so
    // each pattern meets both flip-flop states.
    for (int pass = 0; pass < 2; pass++) begin
      for (int c = 0; c < 4; c++) begin
        for (int v = 0; v < 32; v++) begin
          applyVector(c[1:0], v[4:0] ^ {4'b0, pass[0]});
        end
      end
    end

    // Registered active-low output drives the inverse of a set flip-flop.
    applyVector(2'b00, 5'b01001);
    check("R6", "registered active-low pad", padDrive, 1'b0);
    check("R7", "registered feedback", feedback, 1'b1);

    // Dedicated input: enable off in combinational mode, the pad level is read back.
    applyVector(2'b11, 5'b10000);
    check("R8", "dedicated input feedback", feedback, 1'b1);
    check("R8", "dedicated input high-Z", padOe, 1'b0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule